// File: doc/BRIEF.md
# Nickel-and-Dime Vend Controller

This block is the control state machine for a single-slot vending machine that releases one item once fifteen cents have been put in. The coin sensor gives a one-clock pulse on `nickel_i` for a five-cent coin and on `dime_i` for a ten-cent coin. The controller keeps the running credit in one of four levels: 0, 5, 10 and 15 cents. Any deposit that would go past fifteen stops at the fifteen-cent level. No change is given.

Two parameters fix the implementation. `ONE_HOT` chooses between a two-bit binary state register and a four-bit one-hot register. `REG_OUT` chooses how `open_o` is formed. In the decoded form it comes from the current state. In the registered form it comes from a flip-flop that is loaded from the next-state logic, so it needs no decoding after the clock edge. All four builds show the same cycle timing at their ports. The only difference is how `open_o` behaves between clock edges while reset is asserted.

Top module: `vend_ctrl`

## Requirements
- R1: After reset the credit is 0. A nickel pulse adds 5 cents and a dime pulse adds 10 cents, and the sum stops at 15. `open_o` is high exactly when the credit is 15 and low at 0, 5 and 10.
- R2: `open_o` rises in the cycle that follows the rising clock edge that samples the coin bringing the credit to 15. This holds for the sequences nickel-nickel-nickel, nickel-dime, dime-nickel and dime-dime.
- R3: A cycle with both coin inputs low leaves the credit unchanged, so idle cycles between coins do not change the result.
- R4: A cycle with both coin inputs high is treated as no coin and leaves the credit unchanged.
- R5: Once `open_o` is high it stays high, whatever coins follow, until a reset.
- R6: Reset is synchronous and active-high. After a rising edge with `rst` high, the credit is 0 and `open_o` is low. In the decoded form (`REG_OUT`=0), `open_o` is also low at any moment `rst` is high.
- R7: With `ONE_HOT`=0 the credit is held as binary 0→00, 5→01, 10→10, 15→11. With `ONE_HOT`=1 it is held as one-hot, with bit 0 for 0 cents up to bit 3 for 15 cents. Both encodings give the same port behaviour.
- R8: With `REG_OUT`=1, `open_o` changes only at rising clock edges. If `rst` is raised in the middle of a cycle while `open_o` is high, `open_o` stays high until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active-high |
| nickel_i | input | 1 | One-cycle pulse per five-cent coin |
| dime_i | input | 1 | One-cycle pulse per ten-cent coin |
| open_o | output | 1 | Release the item; high while the credit is 15 cents |

## Verification
The hardest case to produce from the ports is the difference between the two output forms. Both forms move in the same cycle at every edge and only separate when reset arrives between edges while the chute is open. The bench runs four builds side by side on the same inputs: every coin sequence of length four over none, nickel, dime and both, then a few more coins. After that it reaches fifteen cents and raises reset half a cycle before an edge. At that point the decoded builds must already be low and the registered builds must still be high.

// File: rtl/vend_pkg.sv
package vend_pkg;
    localparam int LEVELS = 4;
    localparam int BIN_W  = $clog2(LEVELS);

    localparam logic [BIN_W-1:0] BIN_C0  = 2'b00;
    localparam logic [BIN_W-1:0] BIN_C15 = 2'b11;
    localparam logic [LEVELS-1:0] OH_C0  = 4'b0001;

    typedef struct packed {
        logic [BIN_W-1:0] st;
    } bin_regs_t;

    typedef struct packed {
        logic [LEVELS-1:0] st;
    } oh_regs_t;

    typedef struct packed {
        logic opn;
    } out_regs_t;

    // qualified coin strobes: simultaneous pulses count as nothing
    typedef struct packed {
        logic five;
        logic ten;
    } coin_t;

    function automatic coin_t qualify(input logic nick, input logic dime);
        coin_t c;
        c.five = nick & ~dime;
        c.ten  = dime & ~nick;
        return c;
    endfunction
endpackage

// File: rtl/vend_state_bin.sv
module vend_state_bin
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nick,
    input  logic dime,
    output logic full_now,
    output logic full_next
);
    bin_regs_t r_q, r_d;
    coin_t     c;
    logic      q1, q0;

    always_comb begin
        c  = qualify(nick, dime);
        q1 = r_q.st[1];
        q0 = r_q.st[0];
        r_d.st[1] = q1 | c.ten | (q0 & c.five);
        r_d.st[0] = (~q0 & c.five) | (q0 & ~c.five) | (q1 & c.five) | (q1 & c.ten);
        if (rst) r_d.st = BIN_C0;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign full_now  = (r_q.st == BIN_C15);
    assign full_next = r_d.st[1] & r_d.st[0];

    AST_BIN_RST: assert property (@(posedge clk) rst |=> r_q.st == BIN_C0); // R6
    AST_BIN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!nick && !dime) |=> $stable(r_q.st)); // R3
    AST_BIN_BOTH: assert property (@(posedge clk) disable iff (rst)
        (nick && dime) |=> $stable(r_q.st)); // R4
    AST_BIN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == BIN_C15) |=> (r_q.st == BIN_C15)); // R5
endmodule

// File: rtl/vend_state_oh.sv
module vend_state_oh
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nick,
    input  logic dime,
    output logic full_now,
    output logic full_next
);
    oh_regs_t r_q, r_d;
    coin_t    c;
    logic     idle;

    always_comb begin
        c    = qualify(nick, dime);
        idle = ~c.five & ~c.ten;
        r_d.st[0] = r_q.st[0] & idle;
        r_d.st[1] = (r_q.st[0] & c.five) | (r_q.st[1] & idle);
        r_d.st[2] = (r_q.st[0] & c.ten) | (r_q.st[1] & c.five) | (r_q.st[2] & idle);
        r_d.st[3] = (r_q.st[1] & c.ten) | (r_q.st[2] & c.ten)
                  | (r_q.st[2] & c.five) | r_q.st[3];
        if (rst) r_d.st = OH_C0;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign full_now  = r_q.st[LEVELS-1];
    assign full_next = r_d.st[LEVELS-1];

    AST_OH_RST: assert property (@(posedge clk) rst |=> r_q.st == OH_C0); // R6
    AST_OH_ONE: assert property (@(posedge clk) disable iff (rst)
        $countones(r_q.st) == 1); // R7
    AST_OH_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!nick && !dime) |=> $stable(r_q.st)); // R3
    AST_OH_BOTH: assert property (@(posedge clk) disable iff (rst)
        (nick && dime) |=> $stable(r_q.st)); // R4
endmodule

// File: rtl/vend_open_stage.sv
module vend_open_stage
    import vend_pkg::*;
#(
    parameter bit REG_OUT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic full_now,
    input  logic full_next,
    output logic open_o
);
    generate
        if (REG_OUT) begin : g_reg
            out_regs_t o_q, o_d;
            always_comb begin
                o_d.opn = full_next & ~rst;
            end
            always_ff @(posedge clk) begin
                o_q <= o_d;
            end
            assign open_o = o_q.opn;
            AST_REG_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
                $stable(full_now) |=> (open_o == full_now)); // R8
        end else begin : g_dec
            assign open_o = full_now & ~rst;
        end
    endgenerate

    AST_OPEN_CLR: assert property (@(posedge clk) rst |=> !open_o); // R6
    AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (rst)
        open_o |=> open_o); // R5
    AST_OPEN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        full_next |=> open_o); // R2
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0,
    parameter bit REG_OUT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic nickel_i,
    input  logic dime_i,
    output logic open_o
);
    logic full_now, full_next;

    generate
        if (ONE_HOT) begin : g_oh
            vend_state_oh u_state (
                .clk(clk), .rst(rst), .nick(nickel_i), .dime(dime_i),
                .full_now(full_now), .full_next(full_next)
            );
        end else begin : g_bin
            vend_state_bin u_state (
                .clk(clk), .rst(rst), .nick(nickel_i), .dime(dime_i),
                .full_now(full_now), .full_next(full_next)
            );
        end
    endgenerate

    vend_open_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk(clk), .rst(rst), .full_now(full_now), .full_next(full_next),
        .open_o(open_o)
    );
endmodule

// File: tb/sim_vend_ctrl.sv
module sim_vend_ctrl;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nick = 1'b0;
    logic dime = 1'b0;
    logic op0, op1, op2, op3;
    int   nchk = 0;
    int   nbad = 0;
    int   credit = 0;

    always #(PERIOD/2) clk = ~clk;

    // u0 binary/decoded, u1 binary/registered, u2 one-hot/decoded, u3 one-hot/registered
    vend_ctrl #(.ONE_HOT(1'b0), .REG_OUT(1'b0)) u0 (.clk(clk), .rst(rst), .nickel_i(nick), .dime_i(dime), .open_o(op0));
    vend_ctrl #(.ONE_HOT(1'b0), .REG_OUT(1'b1)) u1 (.clk(clk), .rst(rst), .nickel_i(nick), .dime_i(dime), .open_o(op1));
    vend_ctrl #(.ONE_HOT(1'b1), .REG_OUT(1'b0)) u2 (.clk(clk), .rst(rst), .nickel_i(nick), .dime_i(dime), .open_o(op2));
    vend_ctrl #(.ONE_HOT(1'b1), .REG_OUT(1'b1)) u3 (.clk(clk), .rst(rst), .nickel_i(nick), .dime_i(dime), .open_o(op3));

    task automatic chk(input string tag, input logic got, input logic exp);
        nchk++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic exp);
        chk({tag, " u0"}, op0, exp);
        chk({tag, " u1"}, op1, exp);
        chk({tag, " u2"}, op2, exp);
        chk({tag, " u3 R7"}, op3, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; nick = 1'b0; dime = 1'b0;
        @(posedge clk); #1;
        chk_all("R6 reset", 1'b0);
        @(negedge clk);
        rst = 1'b0;
        credit = 0;
    endtask

    // sym: 0 none, 1 nickel, 2 dime, 3 both
    task automatic step(input int sym, input string tag_in);
        string tag;
        @(negedge clk);
        nick = (sym == 1) || (sym == 3);
        dime = (sym == 2) || (sym == 3);
        if (tag_in != "")      tag = tag_in;
        else if (credit >= 15) tag = "R5";
        else if (sym == 3)     tag = "R4";
        else if (sym == 0)     tag = "R3";
        else                   tag = "R1";
        if (sym == 1) credit += 5;
        if (sym == 2) credit += 10;
        if (credit > 15) credit = 15;
        @(posedge clk); #1;
        chk_all(tag, credit == 15);
    endtask

    initial begin
        #(PERIOD * 200000);
        nbad++;
        $display("FAIL watchdog got=running exp=finished");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        do_reset();
        // R2 named sequences
        step(1, "R2 NNN"); step(1, "R2 NNN"); step(1, "R2 NNN");
        do_reset();
        step(1, "R2 ND"); step(2, "R2 ND");
        do_reset();
        step(2, "R2 DN"); step(1, "R2 DN");
        do_reset();
        step(2, "R2 DD"); step(2, "R2 DD");
        step(0, "R5 hold"); step(1, "R5 hold");

        // exhaustive length-4 sweep plus trailing coins (R1 R3 R4 R5)
        for (int s = 0; s < 256; s++) begin
            do_reset();
            for (int k = 0; k < 4; k++) step((s >> (2 * k)) & 3, "");
            step(1, ""); step(2, "");
        end

        // R8 / R6: reset raised between edges while open
        do_reset();
        step(2, "R1"); step(2, "R1");
        @(negedge clk);
        nick = 1'b0; dime = 1'b0; rst = 1'b1;
        #1;
        chk("R6 dec u0", op0, 1'b0);
        chk("R8 reg u1", op1, 1'b1);
        chk("R6 dec u2", op2, 1'b0);
        chk("R8 reg u3", op3, 1'b1);
        @(posedge clk); #1;
        chk_all("R6 after edge", 1'b0);
        @(negedge clk);
        rst = 1'b0;
        credit = 0;
        step(1, "R6 credit0"); step(0, "R6 credit0"); step(2, "R6 credit0");

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule